// File: doc/BRIEF.md
# Packet Digest Generator and Checker

This block adds and verifies a 32-bit end-to-end integrity code on transaction-layer packets. Packets enter as a stream of 32-bit dwords with first-dword and last-dword markers and leave on a matching output stream. In generate mode the block marks the header as carrying a digest, folds every dword into the code, and appends the complemented code as one extra trailing dword. In check mode the block forwards the packet unchanged and treats the last dword as the received digest. It recomputes the code over every earlier dword and flags a mismatch.

Both streams use valid/ready. A beat moves when valid and ready are both high on a rising clock edge. The data path is a straight pass: `in_ready` follows `out_ready`, so a stalled sink stalls the source in the same cycle, and the code register holds while no beat moves. While the appended digest is being offered, `in_ready` stays low. The source must hold a beat's data and markers stable until the beat is taken. Mode is a plain level input. It is sampled on the first dword of each packet and kept for the rest of that packet.

Top module: `ecrc_engine`

## Requirements
- R1: The digest is the bitwise complement of a 32-bit CRC with generator 0x04C11DB7 and an all-ones seed at each packet start. Bits are taken in this order: byte 0 = data[7:0] first, then data[15:8], data[23:16], data[31:24], bit 0 of each byte first, dword after dword. This equals the common reflected CRC-32 over the little-endian byte stream.
- R2: In the first dword, bit 0 (low bit of the type field) and bit 22 (poisoned flag) are hashed as 1 whatever their value. Changing them neither changes a generated digest nor causes a check error.
- R3: In generate mode (`mode_chk`=0 at the first dword), each input dword is forwarded in order with `out_eop` low. One more dword carrying the digest follows with `out_eop` high, and `in_ready` is low while it is offered.
- R4: In generate mode, the first output dword has bit 23 (digest-present flag) set, and the code is computed with that bit set.
- R5: In check mode (`mode_chk`=1 at the first dword) with bit 23 of the first dword set, the last dword is excluded from the code and compared with the complemented code. `crc_err` pulses on a mismatch.
- R6: In check mode with bit 23 of the first dword clear, `crc_err` never rises for that packet.
- R7: `done` pulses for one cycle in the cycle after the last dword is taken in check mode, or after the digest dword is taken in generate mode. `crc_err` is high only together with `done`.
- R8: While `out_ready` is low, `in_ready` is low and the code register holds. An offered digest dword stays valid and unchanged until it is taken.
- R9: In check mode, every dword, including the digest, is forwarded unchanged. `out_sop` is set on the first dword and `out_eop` on the last.
- R10: After reset, `done` and `crc_err` are low and no digest is pending.
- R11: A change of `mode_chk` after the first dword has no effect on the packet in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_chk | input | 1 | 0 = generate, 1 = check; sampled at the first dword |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_data | input | 32 | Input dword |
| in_sop | input | 1 | First dword of packet |
| in_eop | input | 1 | Last dword of packet |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Sink accepts output beat |
| out_data | output | 32 | Output dword |
| out_sop | output | 1 | First dword of output packet |
| out_eop | output | 1 | Last dword of output packet |
| done | output | 1 | One-cycle pulse at packet completion |
| crc_err | output | 1 | Digest mismatch, valid with done |

## Verification
The assertions assume the source keeps beats well formed: every packet opens with `in_sop` and closes with `in_eop`, and a check-mode packet that carries a digest has at least two dwords. The assertions also assume the source does not change an offered beat before it is taken. The driver task produces only such packets, holding each beat until the handshake at the following edge. It deliberately toggles `mode_chk` on every dword after the first. The sink's ready follows a pseudo-random pattern in several phases, so stalls fall both on data dwords and on the appended digest.

// File: rtl/ecrc_pkg.sv
package ecrc_pkg;

  localparam int DW = 32;
  localparam logic [DW-1:0] SEED = '1;

  typedef enum logic {ST_FLOW, ST_DIGEST} ecrc_state_t;

  // Mirror a polynomial so the register can shift toward bit 0.
  function automatic logic [DW-1:0] reflect32(input logic [DW-1:0] v);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = v[DW-1-i];
    return r;
  endfunction

  // Fold one dword, bit 0 first, into a reflected CRC state.
  function automatic logic [DW-1:0] crc_fold(input logic [DW-1:0] state,
                                             input logic [DW-1:0] word,
                                             input logic [DW-1:0] poly_r);
    logic [DW-1:0] c;
    logic          fb;
    c = state;
    for (int i = 0; i < DW; i++) begin
      fb = c[0] ^ word[i];
      c  = c >> 1;
      if (fb) c = c ^ poly_r;
    end
    return c;
  endfunction

endpackage

// File: rtl/ecrc_hdr_prep.sv
module ecrc_hdr_prep #(
  parameter int TYPE0_BIT = 0,
  parameter int EP_BIT    = 22,
  parameter int TD_BIT    = 23
) (
  input  logic [ecrc_pkg::DW-1:0] raw,
  input  logic                    first,
  input  logic                    gen,
  output logic [ecrc_pkg::DW-1:0] hash_word,
  output logic [ecrc_pkg::DW-1:0] emit_word
);
  always_comb begin
    hash_word = raw;
    emit_word = raw;
    if (first) begin
      hash_word[TYPE0_BIT] = 1'b1;
      hash_word[EP_BIT]    = 1'b1;
      if (gen) begin
        hash_word[TD_BIT] = 1'b1;
        emit_word[TD_BIT] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ecrc_accum.sv
module ecrc_accum #(
  parameter logic [ecrc_pkg::DW-1:0] POLY = 32'h04C11DB7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd,
  input  logic                    restart,
  input  logic [ecrc_pkg::DW-1:0] word,
  output logic [ecrc_pkg::DW-1:0] crc_q
);
  localparam logic [ecrc_pkg::DW-1:0] POLY_R = ecrc_pkg::reflect32(POLY);

  logic [ecrc_pkg::DW-1:0] crc_nxt;

  always_comb
    crc_nxt = ecrc_pkg::crc_fold(restart ? ecrc_pkg::SEED : crc_q, word, POLY_R);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_q <= ecrc_pkg::SEED;
    else if (upd) crc_q <= crc_nxt;
  end

  // R8: without an update the running code is frozen
  p_crc_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(crc_q));
endmodule

// File: rtl/ecrc_engine.sv
module ecrc_engine #(
  parameter int TYPE0_BIT = 0,
  parameter int EP_BIT    = 22,
  parameter int TD_BIT    = 23,
  parameter logic [31:0] POLY = 32'h04C11DB7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_chk,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  input  logic        in_sop,
  input  logic        in_eop,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic        out_sop,
  output logic        out_eop,
  output logic        done,
  output logic        crc_err
);
  import ecrc_pkg::*;

  ecrc_state_t   st_q;
  logic          mode_q, td_q;
  logic          chk_now, td_now, acc, flow, upd, digest_bad;
  logic [DW-1:0] hash_word, emit_word, crc_q;

  assign flow     = (st_q == ST_FLOW);
  assign chk_now  = in_sop ? mode_chk : mode_q;
  assign td_now   = in_sop ? in_data[TD_BIT] : td_q;
  assign in_ready = flow && out_ready;
  assign acc      = in_valid && in_ready;
  // the received digest of a check-mode packet is kept out of the code
  assign upd      = acc && !(chk_now && td_now && in_eop && !in_sop);

  ecrc_hdr_prep #(.TYPE0_BIT(TYPE0_BIT), .EP_BIT(EP_BIT), .TD_BIT(TD_BIT)) u_prep (
    .raw(in_data), .first(in_sop), .gen(!chk_now),
    .hash_word(hash_word), .emit_word(emit_word)
  );

  ecrc_accum #(.POLY(POLY)) u_acc (
    .clk(clk), .rst_n(rst_n), .upd(upd), .restart(in_sop),
    .word(hash_word), .crc_q(crc_q)
  );

  assign digest_bad = (in_data != ~crc_q);

  assign out_valid = flow ? in_valid : 1'b1;
  assign out_data  = flow ? emit_word : ~crc_q;
  assign out_sop   = flow && in_sop;
  assign out_eop   = flow ? (in_eop && chk_now) : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_FLOW;
      mode_q  <= 1'b0;
      td_q    <= 1'b0;
      done    <= 1'b0;
      crc_err <= 1'b0;
    end else begin
      if (acc && in_sop) begin
        mode_q <= mode_chk;
        td_q   <= in_data[TD_BIT];
      end
      if (flow && acc && in_eop && !chk_now) st_q <= ST_DIGEST;
      else if (!flow && out_ready)           st_q <= ST_FLOW;
      done    <= (acc && in_eop && chk_now) || (!flow && out_ready);
      crc_err <= acc && in_eop && chk_now && td_now && !in_sop && digest_bad;
    end
  end

  // R7: an error report always comes with the completion pulse
  p_err_needs_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err |-> done);
  // R7: taking the digest completes the packet one cycle later
  p_digest_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow && out_ready) |=> done);
  // R8: a stalled sink stalls the source
  p_bp_blocks_input_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> !in_ready);
  // R8: a pending digest stays offered and unchanged
  p_digest_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!flow && !out_ready) |=> (out_valid && $stable(out_data)));
  // R6: packets without a digest never report a mismatch
  p_plain_no_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_eop && chk_now && !td_now) |=> !crc_err);
  // R4: generated packets announce the digest in their header
  p_gen_sets_td_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop && !chk_now) |-> out_data[TD_BIT]);
endmodule

// File: tb/ecrc_engine_test.sv
module ecrc_engine_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        mode_chk = 1'b0, in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [31:0] in_data = '0;
  logic        out_ready = 1'b1;
  logic        in_ready, out_valid, out_sop, out_eop, done, crc_err;
  logic [31:0] out_data;

  int checks = 0, failures = 0;
  bit bp_on = 1'b0, bp_force = 1'b0, finished = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  logic [33:0] exp_q[$];
  string       exp_tag[$];
  bit          err_q[$];
  string       err_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ecrc_engine uut (
    .clk(clk), .rst_n(rst_n), .mode_chk(mode_chk),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .done(done), .crc_err(crc_err)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] crc_bytes(input logic [7:0] b[$]);
    logic [31:0] c = '1;
    foreach (b[i]) begin
      c ^= {24'h0, b[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return ~c;
  endfunction

  function automatic logic [31:0] crc_dwords(input logic [31:0] w[$]);
    logic [7:0] b[$];
    foreach (w[i]) for (int k = 0; k < 4; k++) b.push_back(w[i][8*k +: 8]);
    return crc_bytes(b);
  endfunction

  // header: [4:0] type, [6:5] fmt, [22] poisoned, [23] digest flag, {[17:16],[31:24]} length
  function automatic logic [31:0] mk_hdr(input logic [1:0] fmt, input logic [4:0] typ,
                                         input logic [9:0] len, input bit td, input bit ep);
    return {len[7:0], td, ep, 4'h0, len[9:8], 8'h5A, 1'b0, fmt, typ};
  endfunction

  function automatic void build(input logic [1:0] fmt, input logic [4:0] typ, input int plen,
                                input bit td, input bit ep, input int seed, ref logic [31:0] q[$]);
    q.delete();
    q.push_back(mk_hdr(fmt, typ, 10'(plen), td, ep));
    q.push_back(32'h1234_0000 + seed);
    q.push_back(32'hC0DE_0000 ^ (seed << 4));
    if (fmt[0]) q.push_back(32'h8000_0F00 + seed);
    if (fmt[1]) for (int i = 0; i < plen; i++) q.push_back(32'h9E37_79B9 * (i + 1) + seed);
  endfunction

  task automatic drive_pkt(input logic [31:0] q[$], input bit m);
    @(posedge clk); #1;
    foreach (q[i]) begin
      in_valid = 1'b1; in_data = q[i];
      in_sop = (i == 0); in_eop = (i == q.size() - 1);
      mode_chk = (i == 0) ? m : !m;   // R11: later toggles must be ignored
      do @(negedge clk); while (!in_ready);
      @(posedge clk); #1;
    end
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic drain(input string tag);
    for (int i = 0; i < 5000 && (exp_q.size() != 0 || err_q.size() != 0); i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0 && err_q.size() == 0, tag, 64'(exp_q.size() + err_q.size()), 0);
  endtask

  task automatic send_gen(input logic [31:0] body[$], input string tag);
    logic [31:0] h[$];
    h = body;
    h[0] = h[0] | 32'h00C0_0001;
    foreach (body[i]) begin
      exp_q.push_back({(i == 0), 1'b0, (i == 0) ? (body[i] | 32'h0080_0000) : body[i]});
      exp_tag.push_back(tag);
    end
    exp_q.push_back({1'b0, 1'b1, crc_dwords(h)});
    exp_tag.push_back(tag);
    err_q.push_back(1'b0); err_tag.push_back(tag);
    drive_pkt(body, 1'b0);
    drain(tag);
  endtask

  task automatic send_chk(input logic [31:0] pkt[$], input bit exp_err, input string tag);
    foreach (pkt[i]) begin
      exp_q.push_back({(i == 0), (i == pkt.size() - 1), pkt[i]});
      exp_tag.push_back(tag);
    end
    err_q.push_back(exp_err); err_tag.push_back(tag);
    drive_pkt(pkt, 1'b1);
    drain(tag);
  endtask

  function automatic logic [31:0] digest_for(input logic [31:0] body[$]);
    logic [31:0] h[$];
    h = body;
    h[0] = h[0] | 32'h0040_0001;
    return crc_dwords(h);
  endfunction

  // monitor: sampled mid-cycle, a handshake seen here completes at the next edge
  initial forever begin
    @(negedge clk);
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R3/R9 unexpected beat", 64'(out_data), 0);
      else begin
        logic [33:0] e;
        string t;
        e = exp_q.pop_front(); t = exp_tag.pop_front();
        chk({out_sop, out_eop, out_data} == e, t, 64'({out_sop, out_eop, out_data}), 64'(e));
      end
    end
    if (rst_n && (done || crc_err)) begin
      if (err_q.size() == 0) chk(1'b0, "R7 unexpected done", 64'({done, crc_err}), 0);
      else begin
        bit ee;
        string t;
        ee = err_q.pop_front(); t = err_tag.pop_front();
        chk(done && crc_err == ee, {t, " R5/R6/R7 err"}, 64'({done, crc_err}), 64'({1'b1, ee}));
      end
    end
  end

  // sink ready pattern
  initial forever begin
    @(posedge clk); #1;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = bp_force ? 1'b0 : (bp_on ? (lfsr[0] | lfsr[5]) : 1'b1);
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] p[$];
    logic [7:0]  s[$];
    s = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    chk(crc_bytes(s) == 32'hCBF43926, "R1 model self-test", 64'(crc_bytes(s)), 64'hCBF43926);

    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!done && !crc_err && !out_valid && in_ready, "R10 reset state",
        64'({done, crc_err, out_valid, in_ready}), 64'b0001);

    // generate mode
    build(2'b00, 5'h04, 0, 0, 0, 1, p);  send_gen(p, "R1/R3/R4 gen 3DW");
    build(2'b11, 5'h00, 5, 0, 0, 2, p);  send_gen(p, "R1/R3 gen 4DW+5");
    build(2'b00, 5'h05, 0, 0, 1, 1, p);  send_gen(p, "R2 gen variant bits");
    p = '{32'hDEAD_BEEF};                send_gen(p, "R3 gen single dword");
    bp_on = 1'b1;
    build(2'b10, 5'h00, 9, 0, 0, 3, p);  send_gen(p, "R8 gen backpressure");
    build(2'b01, 5'h0A, 0, 0, 1, 4, p);  send_gen(p, "R8 gen backpressure 4DW");
    bp_on = 1'b0;

    // check mode
    build(2'b10, 5'h00, 2, 1, 0, 5, p);  p.push_back(digest_for(p));
    send_chk(p, 1'b0, "R5/R9 chk good");
    build(2'b10, 5'h00, 2, 1, 0, 5, p);  p.push_back(digest_for(p)); p[4] = p[4] ^ 32'h0000_0100;
    send_chk(p, 1'b1, "R5 chk payload error");
    build(2'b00, 5'h04, 0, 1, 0, 6, p);  p.push_back(digest_for(p) ^ 32'h8000_0000);
    send_chk(p, 1'b1, "R5 chk digest error");
    build(2'b00, 5'h04, 0, 1, 0, 7, p);  p.push_back(digest_for(p)); p[0] = p[0] | 32'h0040_0001;
    send_chk(p, 1'b0, "R2 chk variant bits flipped");
    build(2'b10, 5'h00, 3, 0, 0, 8, p);  p.push_back(32'h0BAD_0BAD);
    send_chk(p, 1'b0, "R6 chk no digest");
    bp_on = 1'b1;
    build(2'b11, 5'h00, 16, 1, 0, 9, p); p.push_back(digest_for(p));
    send_chk(p, 1'b0, "R8 chk backpressure good");
    build(2'b11, 5'h00, 16, 1, 0, 9, p); p.push_back(digest_for(p)); p[1] = p[1] + 1;
    send_chk(p, 1'b1, "R8 chk backpressure bad");
    bp_on = 1'b0;

    // R8: a blocked sink blocks the source at the ports
    bp_force = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b1; in_sop = 1'b1; in_data = 32'h0000_0004; mode_chk = 1'b0;
    @(negedge clk);
    chk(!in_ready && out_valid, "R8 stall", 64'({in_ready, out_valid}), 64'b01);
    @(posedge clk); #1;
    in_valid = 1'b0; in_sop = 1'b0; bp_force = 1'b0;
    repeat (3) @(negedge clk);
    chk(!done && !crc_err, "R8 stall no completion", 64'({done, crc_err}), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule